// File: doc/BRIEF.md
# Two-Context Switch-on-Miss Thread Controller

This block decides which of two hardware thread contexts feeds a single in-order pipeline. Only one context issues at a time: the foreground context. The other context waits in the background. The pipeline reports a miss for the foreground context and classifies it as long (a second-level cache miss) or short (a first-level miss). The memory side reports the completion of each context's outstanding miss on a separate line for each context.

A long miss always hands the pipeline to the other context. A short miss hands it over only when the other context can run; otherwise the foreground context stalls in place. When the stalled foreground context sees the background context's miss complete, it gives way. Each handover produces a single-cycle flush pulse, because the in-order pipeline drains and restarts. The incoming context then waits a parameterised number of cycles before it may issue. An enable input pins execution to context 0.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: After reset, context 0 is active, both contexts are ready, `flush_o` is low and `issue_ok_o` is high.
- R2: A miss is accepted only in a cycle where `issue_ok_o` is high. An accepted miss clears `ready_o[active_o]` from the next cycle, and that bit stays low until `done_i` for that context is seen. `ready_o` bit t belongs to context t.
- R3: When an accepted miss and `done_i` for the same context fall in the same cycle, the completion wins and the context stays ready.
- R4: With enable high, an accepted long miss (`miss_long_i`=1) that is not cancelled by a completion makes the other context active in the next cycle.
- R5: With enable high, an accepted short miss (`miss_long_i`=0) switches contexts only if the other context is ready after that cycle's completions. Otherwise the active context is kept and stalls.
- R6: With enable high, if the active context is waiting and the other context is ready after that cycle's completions, the controller switches to the other context.
- R7: A long miss while the other context is also waiting still swaps the active context. Issue stays blocked until one of the two contexts completes.
- R8: `flush_o` is high for exactly one cycle in each cycle where `active_o` differs from its value in the previous cycle, and is low otherwise.
- R9: After a switch, `issue_ok_o` stays low for PENALTY_CYC cycles, beginning with the flush cycle. Misses offered while `issue_ok_o` is low are ignored.
- R10: With enable low, the controller never switches between contexts. If context 1 is active, it returns to context 0 at the next edge, with one flush. While enable is low, only context 0 runs.
- R11: `issue_ok_o` is high exactly when the active context is ready and no penalty is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Multithreading enable; low keeps context 0 running |
| miss_vld_i | input | 1 | The active context reports a miss this cycle |
| miss_long_i | input | 1 | Miss class: 1 = long latency, 0 = short latency |
| done_i | input | 2 | Miss completion, one bit per context |
| active_o | output | 1 | Identifier of the foreground context |
| flush_o | output | 1 | One-cycle pulse on every change of context |
| issue_ok_o | output | 1 | The foreground context may issue this cycle |
| ready_o | output | 2 | Per-context ready flag (not waiting on a miss) |

## Verification
The bench builds the controller with PENALTY_CYC = 3. This makes the blocked-issue window long enough to show misses being ignored during it. It also lets a second switch occur inside a running penalty when both contexts were waiting. Random miss and completion streams, with enable mostly high, reach the cases where a completion and a miss coincide, as well as double-wait swaps. A phase with enable low checks that the controller returns to context 0 and stays there.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
   localparam int unsigned NUM_CTX = 2;
   localparam int unsigned MAX_PENALTY = 64;
   typedef logic ctx_id_t;

   function automatic ctx_id_t peer_ctx(input ctx_id_t id);
      return ~id;
   endfunction
endpackage

// File: rtl/cgmt_wait_track.sv
module cgmt_wait_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic wait_o,
   output logic wait_nxt_o
);
   logic wait_q;

   // completion has priority over a new miss in the same cycle
   assign wait_nxt_o = (wait_q | set_i) & ~clr_i;
   assign wait_o     = wait_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) wait_q <= 1'b0;
      else         wait_q <= wait_nxt_o;
   end
endmodule

// File: rtl/cgmt_switch_decide.sv
module cgmt_switch_decide
   import cgmt_pkg::*;
(
   input  logic                 enable_i,
   input  ctx_id_t              fg_i,
   input  logic [NUM_CTX-1:0]   wait_nxt_i,
   input  logic                 long_acc_i,
   output logic                 switch_o,
   output ctx_id_t              fg_nxt_o
);
   ctx_id_t peer;

   always_comb begin
      peer = peer_ctx(fg_i);
      if (!enable_i) begin
         switch_o = fg_i;
         fg_nxt_o = 1'b0;
      end else begin
         // stalled foreground gives way to a ready peer, or to any peer on a long miss
         switch_o = wait_nxt_i[fg_i] & (~wait_nxt_i[peer] | long_acc_i);
         fg_nxt_o = switch_o ? peer : fg_i;
      end
   end
endmodule

// File: rtl/cgmt_penalty_timer.sv
module cgmt_penalty_timer #(
   parameter int unsigned PENALTY_CYC = 3,
   localparam int unsigned CNT_W = $clog2(PENALTY_CYC + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   output logic busy_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)               cnt_q <= '0;
      else if (load_i)           cnt_q <= CNT_W'(PENALTY_CYC);
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl
   import cgmt_pkg::*;
#(
   parameter int unsigned PENALTY_CYC = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               enable_i,
   input  logic               miss_vld_i,
   input  logic               miss_long_i,
   input  logic [NUM_CTX-1:0] done_i,
   output logic               active_o,
   output logic               flush_o,
   output logic               issue_ok_o,
   output logic [NUM_CTX-1:0] ready_o
);
   if (PENALTY_CYC > MAX_PENALTY) begin : g_bad_penalty
      $error("cgmt_switch_ctrl: PENALTY_CYC above MAX_PENALTY");
   end

   ctx_id_t             fg_q, fg_nxt;
   logic                flush_q;
   logic [NUM_CTX-1:0]  wait_q, wait_nxt;
   logic                pen_busy, miss_acc, sw;

   assign issue_ok_o = ~wait_q[fg_q] & ~pen_busy;
   assign miss_acc   = miss_vld_i & issue_ok_o;

   for (genvar t = 0; t < NUM_CTX; t++) begin : g_ctx
      cgmt_wait_track u_wait (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .set_i      (miss_acc & (fg_q == 1'(t))),
         .clr_i      (done_i[t]),
         .wait_o     (wait_q[t]),
         .wait_nxt_o (wait_nxt[t])
      );
   end

   cgmt_switch_decide u_decide (
      .enable_i   (enable_i),
      .fg_i       (fg_q),
      .wait_nxt_i (wait_nxt),
      .long_acc_i (miss_acc & miss_long_i),
      .switch_o   (sw),
      .fg_nxt_o   (fg_nxt)
   );

   if (PENALTY_CYC == 0) begin : g_no_pen
      assign pen_busy = 1'b0;
   end else begin : g_pen
      cgmt_penalty_timer #(.PENALTY_CYC(PENALTY_CYC)) u_pen (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (sw),
         .busy_o (pen_busy)
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fg_q    <= 1'b0;
         flush_q <= 1'b0;
      end else begin
         fg_q    <= fg_nxt;
         flush_q <= sw;
      end
   end

   assign active_o = fg_q;
   assign flush_o  = flush_q;
   assign ready_o  = ~wait_q;
endmodule

// File: rtl/cgmt_switch_ctrl_chk.sv
module cgmt_switch_ctrl_chk #(
   parameter int unsigned PENALTY_CYC = 3
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       enable_i,
   input logic       miss_vld_i,
   input logic       miss_long_i,
   input logic [1:0] done_i,
   input logic       active_o,
   input logic       flush_o,
   input logic       issue_ok_o,
   input logic [1:0] ready_o
);
   p_flush_on_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_o != $past(active_o)) |-> flush_o);

   p_flush_needs_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_o |-> (active_o != $past(active_o)));

   p_issue_needs_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_ok_o |-> ready_o[active_o]);

   p_done_wins_c0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[0] |=> ready_o[0]);

   p_done_wins_c1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[1] |=> ready_o[1]);

   p_miss_sets_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (miss_vld_i && issue_ok_o && !done_i[active_o]) |=> !ready_o[$past(active_o)]);

   p_long_switch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i && miss_vld_i && miss_long_i && issue_ok_o && !done_i[active_o])
      |=> flush_o);

   p_disabled_ctx0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (active_o == 1'b0));

   if (PENALTY_CYC > 0) begin : g_pen_chk
      p_flush_blocks_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         flush_o |-> !issue_ok_o);
   end
endmodule

bind cgmt_switch_ctrl cgmt_switch_ctrl_chk #(.PENALTY_CYC(PENALTY_CYC)) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .enable_i    (enable_i),
   .miss_vld_i  (miss_vld_i),
   .miss_long_i (miss_long_i),
   .done_i      (done_i),
   .active_o    (active_o),
   .flush_o     (flush_o),
   .issue_ok_o  (issue_ok_o),
   .ready_o     (ready_o)
);

// File: tb/cgmt_switch_ctrl_tb_top.sv
module cgmt_switch_ctrl_tb_top;
   localparam int PEN = 3;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       enable_i = 1'b1;
   logic       miss_vld_i = 1'b0;
   logic       miss_long_i = 1'b0;
   logic [1:0] done_i = 2'b00;
   logic       active_o, flush_o, issue_ok_o;
   logic [1:0] ready_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string tag = "R1";

   // reference model state
   int m_fg = 0;
   bit m_wait[2] = '{0, 0};
   int m_pen = 0;
   bit m_flush = 0;

   always #5 clk = ~clk;

   cgmt_switch_ctrl #(.PENALTY_CYC(PEN)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .miss_vld_i(miss_vld_i),
      .miss_long_i(miss_long_i), .done_i(done_i), .active_o(active_o),
      .flush_o(flush_o), .issue_ok_o(issue_ok_o), .ready_o(ready_o));

   function automatic bit m_issue();
      return !m_wait[m_fg] && (m_pen == 0);
   endfunction

   task automatic model_step();
      bit acc, sw, nw[2];
      int other;
      acc = miss_vld_i && m_issue();
      for (int t = 0; t < 2; t++)
         nw[t] = (m_wait[t] || (acc && m_fg == t)) && !done_i[t];
      other = 1 - m_fg;
      if (!enable_i) begin
         sw = (m_fg == 1);
      end else if (!nw[m_fg]) begin
         sw = 0;                      // foreground not stalled
      end else if (acc && miss_long_i) begin
         sw = 1;                      // long miss always hands over
      end else begin
         sw = !nw[other];             // only to a ready peer
      end
      m_wait = nw;
      if (sw) begin
         m_fg = enable_i ? other : 0;
         m_pen = PEN;
      end else if (m_pen > 0) begin
         m_pen--;
      end
      m_flush = sw;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s (phase %s) actual=%0d expected=%0d at %0t", req, tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R4 active", int'(active_o), m_fg);
      chk("R8 flush", int'(flush_o), int'(m_flush));
      chk("R11 issue_ok", int'(issue_ok_o), int'(m_issue()));
      chk("R2 ready0", int'(ready_o[0]), int'(!m_wait[0]));
      chk("R2 ready1", int'(ready_o[1]), int'(!m_wait[1]));
   endtask

   task automatic cyc(input bit en, input bit mv, input bit ml, input bit [1:0] d);
      enable_i = en; miss_vld_i = mv; miss_long_i = ml; done_i = d;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      tag = "R1";
      chk("R1 active", int'(active_o), 0);
      chk("R1 flush", int'(flush_o), 0);
      chk("R1 issue_ok", int'(issue_ok_o), 1);
      chk("R1 ready", int'(ready_o), 3);

      tag = "R4";          // long miss on ctx0 switches to ctx1
      cyc(1, 1, 1, 2'b00);
      tag = "R9";          // misses during penalty are ignored
      cyc(1, 1, 1, 2'b00); cyc(1, 1, 0, 2'b00);
      idle(2);
      tag = "R5";          // short miss on ctx1 while ctx0 waits: stall
      cyc(1, 1, 0, 2'b00); idle(2);
      tag = "R6";          // ctx0 completes, stalled ctx1 gives way
      cyc(1, 0, 0, 2'b01); idle(4);
      tag = "R5";          // ctx1 completes; short miss on ctx0 with ready peer switches
      cyc(1, 0, 0, 2'b10); cyc(1, 1, 0, 2'b00); idle(4);
      tag = "R7";          // ctx0 still waiting; long miss on ctx1 swaps anyway
      cyc(1, 1, 1, 2'b00); idle(5);
      cyc(1, 0, 0, 2'b10); idle(5);
      cyc(1, 0, 0, 2'b01); idle(4);
      tag = "R3";          // completion wins over a same-cycle miss
      cyc(1, 1, 1, 2'b11); cyc(1, 1, 0, 2'b11); idle(2);
      tag = "R10";         // enable low: return to and stay on ctx0
      cyc(1, 1, 1, 2'b00); idle(4);
      for (int i = 0; i < 300; i++)
         cyc(0, ($urandom % 3) == 0, $urandom % 2, 2'($urandom % 4));
      tag = "R2";          // random streams against the model
      for (int i = 0; i < 4000; i++)
         cyc(($urandom % 16) != 0, ($urandom % 3) == 0, $urandom % 2,
             {($urandom % 5) == 0, ($urandom % 5) == 0});
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule